// File: doc/BRIEF.md
# Word-packed UART transmitter

This block is the transmit half of a UART whose data port is a full 32-bit word. Before pushing data, software programs a character count; every word pushed afterwards is stored in a transmit FIFO together with the count that was active when it was written. An unpacker drains the FIFO one word at a time and hands the counted bytes to a serializer, lowest byte first. The unused upper bytes of a word are never sent.

The serializer builds each frame from a six-bit format register. The register selects the character width, the parity kind and the stop length, and the stop length can be a fractional number of bit cells. Timing comes from an external strobe at sixteen times the bit rate, and the line moves only on strobe cycles. A four-bit status vector reports that the path is completely drained, that a word was lost to a full FIFO, that the FIFO is full, and that the transmitter is enabled. A command port enables the transmitter, flushes the whole path or clears the lost-word error.

Top module: `wpk_uart_tx`

## Requirements
- R1: After reset, `txd` is 1 and `stat` is 4'b1000. The format register holds 6'h34 (8 data bits, no parity, one stop bit) and the character count is 0, so a word written before any count write is discarded.
- R2: The bytes of a word go out in order byte 0 (bits 7:0), then byte 1, and so on. A word sends exactly the count that was in force when it was written, even if the count is rewritten before the word is sent.
- R3: A count write above 4 is stored as 4. While the count is 0, word writes are discarded: nothing is sent and `stat[3]` stays set.
- R4: A frame is a low start cell followed by the data bits, least significant bit first. The width field `mode_wdata[5:4]` = 0,1,2,3 selects 5, 6, 7 or 8 bits.
- R5: The parity field `mode_wdata[1:0]` is 0 for none, 1 for odd (the data plus the parity bit hold an odd number of ones), 2 for even, and 3 for a parity bit that is always 0.
- R6: Every start, data and parity cell lasts 16 strobe pulses. The stop field `mode_wdata[3:2]` = 0,1,2,3 gives a high stop of 9, 16, 25 or 32 pulses. When more bytes are queued, the next start cell follows the stop with no gap.
- R7: Until a command write with `cmd_wdata[2]`=1, queued data is held and `txd` stays high. `stat[0]` shows the enable.
- R8: `stat[3]` is 1 only when the FIFO, the unpacker and the serializer all hold nothing. While it is 1, `txd` is high.
- R9: A word write (count nonzero) while `stat[1]` (FIFO full) is 1 is dropped and sets the sticky error `stat[2]`. While disabled, the path holds DEPTH words in the FIFO plus one in the unpacker.
- R10: A command write with code 10 in `cmd_wdata[7:4]` clears `stat[2]` without touching queued data. In the same cycle it takes priority over a new overflow.
- R11: A command write with code 2 in `cmd_wdata[7:4]` discards all queued and in-flight data, drives `txd` high on the next cycle and clears the enable. Words flushed this way are never sent.
- R12: Apart from a flush, `txd` changes only in the cycle after one where `baud_tick` was 1. With the strobe held low, a frame freezes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| mode_we | input | 1 | Format register write strobe |
| mode_wdata | input | 6 | Format: [5:4] width, [3:2] stop, [1:0] parity |
| cnt_we | input | 1 | Character count write strobe |
| cnt_wdata | input | CNTIN_W | Characters per subsequent word (clamped to LANES) |
| word_we | input | 1 | Data word push strobe |
| word_wdata | input | LANES*8 | Packed characters, byte 0 sent first |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 8 | [2] enable, [7:4] channel command code |
| txd | output | 1 | Serial line, idle high |
| stat | output | 4 | [3] drained, [2] lost-word error, [1] FIFO full, [0] enabled |

## Verification
The bench builds the block with a FIFO depth of 4, four byte lanes and 16x oversampling, and toggles the strobe every second clock so that each bit cell is 32 cycles long. A depth of 4 lets the full flag and a dropped word be reached within six writes while the transmitter is disabled. The bench sweeps all four widths, parities and stop lengths, and the spacing it measures between start edges exposes the exact number of strobes each stop length takes. The two-cycle strobe also leaves idle cycles between strobes, so a line change outside a strobe cycle shows up, as does any motion while the strobe is held low.

// File: rtl/wpk_pkg.sv
package wpk_pkg;

   typedef enum logic [1:0] {
      PAR_NONE  = 2'd0,
      PAR_ODD   = 2'd1,
      PAR_EVEN  = 2'd2,
      PAR_SPACE = 2'd3
   } par_e;

   typedef enum logic [1:0] {
      STOP_9_16  = 2'd0,
      STOP_ONE   = 2'd1,
      STOP_25_16 = 2'd2,
      STOP_TWO   = 2'd3
   } stop_e;

   // width field: 0..3 means 5..8 data bits
   typedef struct packed {
      logic [1:0] width;
      stop_e      stop;
      par_e       par;
   } frame_cfg_t;

   localparam frame_cfg_t CFG_RESET = frame_cfg_t'(6'h34);

   localparam logic [3:0] CMD_TX_FLUSH   = 4'd2;
   localparam logic [3:0] CMD_TX_ERR_CLR = 4'd10;

   typedef enum logic [2:0] {
      S_IDLE, S_START, S_DATA, S_PAR, S_STOP
   } ser_state_e;

endpackage

// File: rtl/wpk_tx_fifo.sv
module wpk_tx_fifo #(
   parameter int W     = 35,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("wpk_tx_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp, rp;

   assign empty = (wp == rp);
   assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign dout  = mem[rp[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else if (flush) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push && !full) wp <= wp + 1'b1;
         if (pop && !empty) rp <= rp + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push && !full && !flush) mem[wp[AW-1:0]] <= din;
   end

endmodule

// File: rtl/wpk_byte_unpack.sv
module wpk_byte_unpack #(
   parameter int LANES  = 4,
   parameter int BYTE_W = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush,
   input  logic                         fifo_empty,
   input  logic [LANES*BYTE_W-1:0]      fifo_word,
   input  logic [$clog2(LANES+1)-1:0]   fifo_cnt,
   output logic                         fifo_pop,
   output logic                         byte_valid,
   output logic [BYTE_W-1:0]            byte_data,
   input  logic                         byte_take,
   output logic                         busy
);
   localparam int IW = $clog2(LANES);
   localparam int CW = $clog2(LANES+1);

   generate
      if (LANES < 2) begin : g_bad_lanes
         $error("wpk_byte_unpack: LANES must be at least 2");
      end
   endgenerate

   logic [LANES*BYTE_W-1:0] word_q;
   logic [CW-1:0]           rem_q;
   logic [IW-1:0]           idx_q;
   logic [BYTE_W-1:0]       lane [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane[g] = word_q[g*BYTE_W +: BYTE_W];
   end

   assign busy       = (rem_q != '0);
   assign byte_valid = busy;
   assign byte_data  = lane[idx_q];
   assign fifo_pop   = !busy && !fifo_empty && !flush;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         rem_q  <= '0;
         idx_q  <= '0;
      end else if (flush) begin
         rem_q  <= '0;
         idx_q  <= '0;
      end else if (fifo_pop) begin
         word_q <= fifo_word;
         rem_q  <= fifo_cnt;
         idx_q  <= '0;
      end else if (byte_take && busy) begin
         rem_q  <= rem_q - 1'b1;
         idx_q  <= idx_q + 1'b1;
      end
   end

endmodule

// File: rtl/wpk_frame_ser.sv
module wpk_frame_ser
   import wpk_pkg::*;
#(
   parameter int OSR = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       flush,
   input  logic       tick,
   input  logic       en,
   input  frame_cfg_t cfg,
   input  logic       byte_valid,
   input  logic [7:0] byte_data,
   output logic       byte_take,
   output logic       txd,
   output logic       busy
);
   localparam int TW = $clog2(2*OSR+1);
   localparam logic [TW-1:0] CELL  = TW'(OSR);
   localparam logic [TW-1:0] ST_A  = TW'(OSR*9/16);
   localparam logic [TW-1:0] ST_B  = TW'(OSR);
   localparam logic [TW-1:0] ST_C  = TW'(OSR*25/16);
   localparam logic [TW-1:0] ST_D  = TW'(2*OSR);

   generate
      if (OSR < 16 || (OSR % 16) != 0) begin : g_bad_osr
         $error("wpk_frame_ser: OSR must be a multiple of 16");
      end
   endgenerate

   ser_state_e  st;
   frame_cfg_t  cfg_q;
   logic [TW-1:0] tcnt, ph_len, stop_len;
   logic [7:0]  shreg;
   logic [3:0]  bitn, nbits;
   logic        par_acc, par_bit, last, ld;

   always_comb begin
      case (cfg_q.stop)
         STOP_9_16:  stop_len = ST_A;
         STOP_ONE:   stop_len = ST_B;
         STOP_25_16: stop_len = ST_C;
         default:    stop_len = ST_D;
      endcase
      ph_len = (st == S_STOP) ? stop_len : CELL;
      last   = (tcnt == ph_len - 1'b1);
      nbits  = 4'd5 + {2'b00, cfg_q.width};
      case (cfg_q.par)
         PAR_ODD:  par_bit = ~par_acc;
         PAR_EVEN: par_bit = par_acc;
         default:  par_bit = 1'b0;
      endcase
   end

   assign ld        = tick && en && !flush && byte_valid &&
                      (st == S_IDLE || (st == S_STOP && last));
   assign byte_take = ld;
   assign busy      = (st != S_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         cfg_q   <= CFG_RESET;
         tcnt    <= '0;
         shreg   <= '0;
         bitn    <= '0;
         par_acc <= 1'b0;
         txd     <= 1'b1;
      end else if (flush) begin
         st   <= S_IDLE;
         tcnt <= '0;
         txd  <= 1'b1;
      end else if (tick) begin
         if (ld) begin
            st      <= S_START;
            cfg_q   <= cfg;
            tcnt    <= '0;
            shreg   <= byte_data;
            bitn    <= '0;
            par_acc <= 1'b0;
            txd     <= 1'b0;
         end else if (st != S_IDLE) begin
            if (!last) begin
               tcnt <= tcnt + 1'b1;
            end else begin
               tcnt <= '0;
               case (st)
                  S_START, S_DATA: begin
                     if (st == S_DATA && bitn == nbits) begin
                        if (cfg_q.par == PAR_NONE) begin
                           st  <= S_STOP;
                           txd <= 1'b1;
                        end else begin
                           st  <= S_PAR;
                           txd <= par_bit;
                        end
                     end else begin
                        st      <= S_DATA;
                        txd     <= shreg[0];
                        shreg   <= shreg >> 1;
                        par_acc <= par_acc ^ shreg[0];
                        bitn    <= bitn + 1'b1;
                     end
                  end
                  S_PAR: begin
                     st  <= S_STOP;
                     txd <= 1'b1;
                  end
                  default: begin
                     st  <= S_IDLE;
                     txd <= 1'b1;
                  end
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/wpk_uart_tx.sv
module wpk_uart_tx
   import wpk_pkg::*;
#(
   parameter int DEPTH   = 8,
   parameter int LANES   = 4,
   parameter int OSR     = 16,
   parameter int CNTIN_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 baud_tick,
   input  logic                 mode_we,
   input  logic [5:0]           mode_wdata,
   input  logic                 cnt_we,
   input  logic [CNTIN_W-1:0]   cnt_wdata,
   input  logic                 word_we,
   input  logic [LANES*8-1:0]   word_wdata,
   input  logic                 cmd_we,
   input  logic [7:0]           cmd_wdata,
   output logic                 txd,
   output logic [3:0]           stat
);
   localparam int BYTE_W = 8;
   localparam int WORD_W = LANES*BYTE_W;
   localparam int CW     = $clog2(LANES+1);
   localparam int ENT_W  = WORD_W + CW;

   generate
      if (CNTIN_W < CW) begin : g_bad_cntw
         $error("wpk_uart_tx: CNTIN_W too narrow for LANES");
      end
   endgenerate

   frame_cfg_t    mode_q;
   logic [CW-1:0] cnt_q, cnt_clamped;
   logic          en_q, err_q;
   logic          flush, err_clr, push, lost;
   logic          fifo_full, fifo_empty, fifo_pop;
   logic [ENT_W-1:0] fifo_dout;
   logic          byte_valid, byte_take, unpack_busy, ser_busy;
   logic [BYTE_W-1:0] byte_data;
   logic          unused_cmd_bits;

   assign unused_cmd_bits = ^{cmd_wdata[3], cmd_wdata[1:0]};

   assign flush   = cmd_we && (cmd_wdata[7:4] == CMD_TX_FLUSH);
   assign err_clr = cmd_we && (cmd_wdata[7:4] == CMD_TX_ERR_CLR);
   assign push    = word_we && (cnt_q != '0) && !fifo_full;
   assign lost    = word_we && (cnt_q != '0) && fifo_full;

   assign cnt_clamped = (cnt_wdata > CNTIN_W'(LANES)) ? CW'(LANES)
                                                      : cnt_wdata[CW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= CFG_RESET;
         cnt_q  <= '0;
         en_q   <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (mode_we) mode_q <= frame_cfg_t'(mode_wdata);
         if (cnt_we)  cnt_q  <= cnt_clamped;
         if (flush)                       en_q <= 1'b0;
         else if (cmd_we && cmd_wdata[2]) en_q <= 1'b1;
         if (err_clr)   err_q <= 1'b0;
         else if (lost) err_q <= 1'b1;
      end
   end

   wpk_tx_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (push),
      .din   ({cnt_q, word_wdata}),
      .pop   (fifo_pop),
      .dout  (fifo_dout),
      .full  (fifo_full),
      .empty (fifo_empty)
   );

   wpk_byte_unpack #(.LANES(LANES), .BYTE_W(BYTE_W)) u_unpack (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .fifo_empty (fifo_empty),
      .fifo_word  (fifo_dout[WORD_W-1:0]),
      .fifo_cnt   (fifo_dout[ENT_W-1:WORD_W]),
      .fifo_pop   (fifo_pop),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .byte_take  (byte_take),
      .busy       (unpack_busy)
   );

   wpk_frame_ser #(.OSR(OSR)) u_ser (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .tick       (baud_tick),
      .en         (en_q),
      .cfg        (mode_q),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .byte_take  (byte_take),
      .txd        (txd),
      .busy       (ser_busy)
   );

   assign stat = {fifo_empty && !unpack_busy && !ser_busy, err_q, fifo_full, en_q};

endmodule

// File: rtl/wpk_uart_tx_chk.sv
module wpk_uart_tx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       baud_tick,
   input logic       word_we,
   input logic       cmd_we,
   input logic [7:0] cmd_wdata,
   input logic       txd,
   input logic [3:0] stat
);
   logic flush_cmd, clr_cmd;
   assign flush_cmd = cmd_we && (cmd_wdata[7:4] == 4'd2);
   assign clr_cmd   = cmd_we && (cmd_wdata[7:4] == 4'd10);

   a_r12_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(baud_tick) && !$past(flush_cmd)) |-> $stable(txd));

   a_r8_drained_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      stat[3] |-> txd);

   a_r7_disabled_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      !stat[0] |-> txd);

   a_r9_err_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[2]) |-> $past(stat[1] && word_we));

   a_r9_full_not_drained: assert property (@(posedge clk) disable iff (!rst_n)
      stat[1] |-> !stat[3]);

   a_r10_err_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_cmd) |-> !stat[2]);

   a_r11_flush_drains: assert property (@(posedge clk) disable iff (!rst_n)
      $past(flush_cmd) |-> (stat[3] && !stat[0] && !stat[1] && txd));

endmodule

bind wpk_uart_tx wpk_uart_tx_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .baud_tick (baud_tick),
   .word_we   (word_we),
   .cmd_we    (cmd_we),
   .cmd_wdata (cmd_wdata),
   .txd       (txd),
   .stat      (stat)
);

// File: tb/sim_wpk_uart_tx.sv
module sim_wpk_uart_tx;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 4;
   localparam int DIV        = 2;
   localparam int BITC       = 16*DIV;

   logic        clk, rst_n, baud_tick;
   logic        mode_we, cnt_we, word_we, cmd_we;
   logic [5:0]  mode_wdata;
   logic [7:0]  cnt_wdata, cmd_wdata;
   logic [31:0] word_wdata;
   logic        txd;
   logic [3:0]  stat;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 0, tick_en = 1, mon_en = 1;
   int m_w = 3, m_p = 0;
   int rx_cnt = 0;
   logic [7:0] rx_d [64];
   int         rx_t [64];

   wpk_uart_tx #(.DEPTH(DEPTH), .LANES(4), .OSR(16), .CNTIN_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .mode_we(mode_we), .mode_wdata(mode_wdata),
      .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
      .word_we(word_we), .word_wdata(word_wdata),
      .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
      .txd(txd), .stat(stat));

   initial begin clk = 0; forever #(CLK_PERIOD/2) clk = ~clk; end
   always @(posedge clk) cyc <= cyc + 1;
   initial begin
      baud_tick = 0;
      forever begin @(negedge clk); baud_tick = tick_en ? ~baud_tick : 1'b0; end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // line monitor: decodes frames with the bench's current format
   initial begin
      bit prev; int t0; int nb; logic [7:0] d; logic ep;
      prev = 1;
      forever begin
         @(negedge clk);
         if (mon_en && prev && !txd) begin
            t0 = cyc; d = '0; nb = 5 + m_w;
            repeat (BITC/2) @(negedge clk);
            chk(txd == 0, "R4 start cell low", txd, 0);
            for (int i = 0; i < nb; i++) begin
               repeat (BITC) @(negedge clk);
               d[i] = txd;
            end
            if (m_p != 0) begin
               repeat (BITC) @(negedge clk);
               ep = (m_p == 1) ? ~^d : (m_p == 2) ? ^d : 1'b0;
               chk(txd == ep, "R5 parity bit", txd, ep);
            end
            repeat (BITC) @(negedge clk);
            chk(txd == 1, "R6 stop level", txd, 1);
            if (rx_cnt < 64) begin rx_d[rx_cnt] = d; rx_t[rx_cnt] = t0; end
            rx_cnt++;
         end
         prev = txd;
      end
   end

   task automatic wr_mode(input logic [5:0] v);
      @(negedge clk); mode_we = 1; mode_wdata = v; @(negedge clk); mode_we = 0;
   endtask
   task automatic wr_cnt(input logic [7:0] v);
      @(negedge clk); cnt_we = 1; cnt_wdata = v; @(negedge clk); cnt_we = 0;
   endtask
   task automatic wr_word(input logic [31:0] v);
      @(negedge clk); word_we = 1; word_wdata = v; @(negedge clk); word_we = 0;
   endtask
   task automatic wr_cmd(input logic [7:0] v);
      @(negedge clk); cmd_we = 1; cmd_wdata = v; @(negedge clk); cmd_we = 0;
   endtask
   task automatic wait_idle();
      int k = 0;
      while (!stat[3] && k < 20000) begin @(negedge clk); k++; end
      repeat (40) @(negedge clk);
   endtask
   task automatic wait_low();
      int k = 0;
      while (txd && k < 2000) begin @(negedge clk); k++; end
   endtask

   task automatic t_reset();
      chk(stat == 4'b1000, "R1 reset status", stat, 4'b1000);
      chk(txd == 1, "R1 reset line", txd, 1);
      wr_word(32'hFFFF_FFFF);
      chk(stat == 4'b1000, "R1 count resets to zero", stat, 4'b1000);
   endtask

   task automatic t_hold();
      rx_cnt = 0;
      wr_cnt(8'd4);
      wr_word(32'h4433_2211);
      repeat (300) @(negedge clk);
      chk(rx_cnt == 0, "R7 no frame while disabled", rx_cnt, 0);
      chk(txd == 1, "R7 line high while disabled", txd, 1);
      chk(stat[3] == 0, "R8 not drained with data held", stat, 0);
      wr_cmd(8'h04);
      chk(stat[0] == 1, "R7 enable bit", stat, 1);
      wait_idle();
      chk(rx_cnt == 4, "R2 four bytes sent", rx_cnt, 4);
      for (int i = 0; i < 4; i++)
         chk(rx_d[i] == 8'(8'h11 * (i+1)), "R2 byte order", rx_d[i], 8'h11*(i+1));
      chk(rx_t[1] - rx_t[0] == DIV*160, "R1 default 8N1 frame length",
          rx_t[1] - rx_t[0], DIV*160);
      chk(stat == 4'b1001, "R8 drained after sending", stat, 4'b1001);
   endtask

   task automatic t_count();
      logic [7:0] e [6];
      e[0] = 8'hAA; e[1] = 8'hBB; e[2] = 8'h21; e[3] = 8'h43; e[4] = 8'h65; e[5] = 8'h87;
      rx_cnt = 0;
      wr_cnt(8'd2);
      wr_word(32'hDDCC_BBAA);
      wr_cnt(8'd9);
      wr_word(32'h8765_4321);
      wait_idle();
      chk(rx_cnt == 6, "R3 clamp and per-word count", rx_cnt, 6);
      for (int i = 0; i < 6; i++)
         chk(rx_d[i] == e[i], "R2 counted bytes in order", rx_d[i], e[i]);
      rx_cnt = 0;
      wr_cnt(8'd0);
      wr_word(32'h1234_5678);
      repeat (2) @(negedge clk);
      chk(stat[3] == 1, "R3 zero count keeps drained", stat, 1);
      repeat (400) @(negedge clk);
      chk(rx_cnt == 0, "R3 zero count sends nothing", rx_cnt, 0);
   endtask

   task automatic t_modes();
      int stl [4];
      int n, exp_len;
      logic [7:0] mask;
      stl[0] = 9; stl[1] = 16; stl[2] = 25; stl[3] = 32;
      for (int k = 0; k < 4; k++) begin
         m_w = k; m_p = k;
         wr_mode({k[1:0], k[1:0], k[1:0]});
         rx_cnt = 0;
         wr_cnt(8'd2);
         wr_word(32'h0000_C3A5);
         wait_idle();
         n = 5 + k;
         mask = 8'((1 << n) - 1);
         exp_len = DIV * (16 * (1 + n + ((k != 0) ? 1 : 0)) + stl[k]);
         chk(rx_cnt == 2, "R4 frames per format", rx_cnt, 2);
         chk(rx_d[0] == (8'hA5 & mask), "R4 width byte0", rx_d[0], 8'hA5 & mask);
         chk(rx_d[1] == (8'hC3 & mask), "R4 width byte1", rx_d[1], 8'hC3 & mask);
         chk(rx_t[1] - rx_t[0] == exp_len, "R6 frame and stop length",
             rx_t[1] - rx_t[0], exp_len);
      end
      m_w = 3; m_p = 0;
      wr_mode(6'h34);
   endtask

   task automatic t_overflow();
      wr_cmd(8'h20);
      wr_cnt(8'd1);
      for (int i = 0; i < DEPTH + 1; i++) wr_word(32'(i + 1));
      chk(stat[2:1] == 2'b01, "R9 full without error", stat, 4'b0010);
      wr_word(32'h99);
      chk(stat[2] == 1, "R9 dropped word sets error", stat, 4'b0110);
      wr_cmd(8'hA0);
      chk(stat[2:1] == 2'b01, "R10 error cleared data kept", stat, 4'b0010);
      wr_cmd(8'h20);
      chk(stat == 4'b1000, "R11 flush drains", stat, 4'b1000);
      rx_cnt = 0;
      wr_cmd(8'h04);
      repeat (600) @(negedge clk);
      chk(rx_cnt == 0, "R11 flushed words never sent", rx_cnt, 0);
   endtask

   task automatic t_flush_mid();
      int bad = 0;
      mon_en = 0;
      wr_cnt(8'd4);
      wr_word(32'h0000_0000);
      wait_low();
      repeat (50) @(negedge clk);
      wr_cmd(8'h20);
      chk(txd == 1, "R11 line high after flush", txd, 1);
      chk(stat == 4'b1000, "R11 status after flush", stat, 4'b1000);
      wr_cmd(8'h04);
      repeat (1000) begin @(negedge clk); if (!txd) bad++; end
      chk(bad == 0, "R11 no residue after flush", bad, 0);
      mon_en = 1;
   endtask

   task automatic t_pause();
      int bad = 0; logic v;
      mon_en = 0;
      wr_cnt(8'd1);
      wr_word(32'h0000_005A);
      wait_low();
      repeat (40) @(negedge clk);
      tick_en = 0;
      @(negedge clk);
      v = txd;
      repeat (100) begin @(negedge clk); if (txd !== v) bad++; end
      chk(bad == 0, "R12 frozen without strobe", bad, 0);
      chk(stat[3] == 0, "R12 frame still pending", stat, 0);
      tick_en = 1;
      wait_idle();
      chk(stat[3] == 1, "R12 frame completes on resume", stat, 1);
      mon_en = 1;
   endtask

   initial begin
      rst_n = 0; mode_we = 0; cnt_we = 0; word_we = 0; cmd_we = 0;
      mode_wdata = '0; cnt_wdata = '0; word_wdata = '0; cmd_wdata = '0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_hold();
      t_count();
      t_modes();
      t_overflow();
      t_flush_mid();
      t_pause();
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected completion", cyc);
         summary();
         $finish;
      end
   end

endmodule